// File: doc/BRIEF.md
# Linked-List DMA Channel Sequencer

This block is the control core of one channel of a scatter-gather DMA engine. It holds the channel's current source address, destination address, next-descriptor pointer and remaining beat count. Software sets these through a small register port and then starts the channel. While a packet is moving, the block offers each beat to an external data mover. On every acknowledged beat it steps both addresses by their transfer widths.

When the last beat of a packet is acknowledged, the block checks the next-descriptor pointer. A zero address ends the chain. The channel then drops its enable and active flags together. Otherwise the block reads a four-word descriptor from memory: source, destination, next pointer, and a control word whose low bits give the beat count. The read goes through one of two memory-read ports, picked by bit 0 of the pointer. The block reloads its registers from that descriptor and carries on.

Register map (regAddr): 0 = source address, 1 = destination address, 2 = next-descriptor word, 3 = control. A control write with bit 31 set starts the channel, and bits [CNT_W-1:0] give the beat count. A control read returns the enable flag in bit 31 and the remaining count in the low bits.

Top module: `lli_chain_seq`

## Requirements
- R1: After reset, the source, destination and next-descriptor registers read 0, the enable flag (control bit 31) reads 0, and chanActive, beatReq, m1Req and m2Req are low.
- R2: The next-descriptor register stores bits [31:2] and bit 0 as written, and bit 1 always reads 0.
- R3: A register write while the channel is enabled is ignored. The stored values, including the next-descriptor word, stay unchanged.
- R4: beatSrcAddr and beatDstAddr show the current addresses. Each acknowledged beat adds 2^SRC_LOG2 to the source and 2^DST_LOG2 to the destination.
- R5: A packet issues exactly as many acknowledged beats as its count field. beatReq is only high while chanActive is high.
- R6: A descriptor fetch reads four words at the pointer address with bits [1:0] forced to 0, at offsets 0, 4, 8 and 12, in that order. Pointer bit 0 = 0 uses port 1 (m1) and 1 uses port 2 (m2). Only one port requests at a time.
- R7: A fetch never starts before the last beat of the current packet is acknowledged. No fetch request is ever high together with beatReq.
- R8: After a fetch, the channel takes source from word 0, destination from word 1, the next pointer from word 2 (bit 1 cleared) and the count from the low CNT_W bits of word 3. It then resumes transfers.
- R9: When the pointer address (bits [31:2]) is zero, the channel stops after the last beat without fetching. chanActive and the enable flag fall on the same clock edge.
- R10: A count of zero, whether written by software or loaded from a descriptor, skips the transfer phase. The block goes straight to the fetch-or-stop decision, with chanActive high for one cycle when the chain ends.
- R11: A control-register write with bit 31 set, while idle, starts the channel. chanActive rises on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on regAddr) |
| chanEnabled | output | 1 | Channel enable flag |
| chanActive | output | 1 | Channel busy status |
| beatReq | output | 1 | Beat request to data mover |
| beatAck | input | 1 | Beat accepted by data mover |
| beatSrcAddr | output | 32 | Source address of current beat |
| beatDstAddr | output | 32 | Destination address of current beat |
| m1Req | output | 1 | Descriptor read request, port 1 |
| m1Addr | output | 32 | Descriptor read address, port 1 |
| m1Ack | input | 1 | Read data valid, port 1 |
| m1Data | input | 32 | Read data, port 1 |
| m2Req | output | 1 | Descriptor read request, port 2 |
| m2Addr | output | 32 | Descriptor read address, port 2 |
| m2Ack | input | 1 | Read data valid, port 2 |
| m2Data | input | 32 | Read data, port 2 |

## Verification
The bench builds the block with SRC_LOG2 = 2 and DST_LOG2 = 0. The source then steps by 4 and the destination by 1, so a swapped or shared step size shows up at once. CNT_W stays at 12. The last descriptor's control word has set bits above bit 11 and zeros below, which proves that only the low count bits are used and that a loaded count of zero ends the chain. The chain runs one fetch through each port, so a wrong port choice or a wrong word order shows up in the fetched addresses.

// File: rtl/lli_chain_pkg.sv
package lli_chain_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_FETCH = 2'd2,
    ST_DONE  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic       swWrite;
    logic       beatStep;
    logic       wordCapture;
    logic [1:0] wordIdx;
    logic       descLoad;
  } seqStrobe_t;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_NEXT = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

endpackage

// File: rtl/lli_chain_ctrl.sv
module lli_chain_ctrl
  import lli_chain_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic             startCmd,
  input  logic [CNT_W-1:0] startCount,
  input  logic             beatAck,
  input  logic             fetchAck,
  input  logic [CNT_W-1:0] fetchCount,
  input  logic [CNT_W-1:0] curCount,
  input  logic             curChainEnd,
  input  logic             curSel,
  input  logic             bufChainEnd,
  input  logic             bufSel,
  output seqStrobe_t       strobe,
  output logic             beatReq,
  output logic             fetchReq,
  output logic             fetchSel,
  output logic             chanEnabled,
  output logic             chanActive
);

  seqState_t state;
  logic [1:0] wordIdx;
  logic       selReg;
  logic       enReg;

  always_comb begin
    strobe             = '0;
    strobe.swWrite     = regWe && (state == ST_IDLE);
    strobe.beatStep    = (state == ST_XFER) && beatAck;
    strobe.wordCapture = (state == ST_FETCH) && fetchAck;
    strobe.wordIdx     = wordIdx;
    strobe.descLoad    = (state == ST_FETCH) && fetchAck && (wordIdx == 2'd3);
  end

  assign beatReq     = (state == ST_XFER);
  assign fetchReq    = (state == ST_FETCH);
  assign fetchSel    = selReg;
  assign chanEnabled = enReg;
  assign chanActive  = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= 2'd0;
      selReg  <= 1'b0;
      enReg   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (regWe && startCmd) begin
            enReg <= 1'b1;
            if (startCount != '0) begin
              state <= ST_XFER;
            end else if (!curChainEnd) begin
              state   <= ST_FETCH;
              wordIdx <= 2'd0;
              selReg  <= curSel;
            end else begin
              state <= ST_DONE;
            end
          end
        end
        ST_XFER: begin
          if (beatAck && (curCount == CNT_W'(1))) begin
            if (!curChainEnd) begin
              state   <= ST_FETCH;
              wordIdx <= 2'd0;
              selReg  <= curSel;
            end else begin
              state <= ST_DONE;
            end
          end
        end
        ST_FETCH: begin
          if (fetchAck) begin
            if (wordIdx == 2'd3) begin
              wordIdx <= 2'd0;
              if (fetchCount != '0) begin
                state <= ST_XFER;
              end else if (!bufChainEnd) begin
                state  <= ST_FETCH;
                selReg <= bufSel;
              end else begin
                state <= ST_DONE;
              end
            end else begin
              wordIdx <= wordIdx + 2'd1;
            end
          end
        end
        ST_DONE: begin
          state <= ST_IDLE;
          enReg <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lli_chain_dp.sv
module lli_chain_dp
  import lli_chain_pkg::*;
#(
  parameter int SRC_LOG2 = 2,
  parameter int DST_LOG2 = 2,
  parameter int CNT_W    = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWdata,
  input  logic [31:0]      fetchWord,
  input  logic             chanEnabled,
  output logic [31:0]      regRdata,
  output logic [31:0]      srcAddr,
  output logic [31:0]      dstAddr,
  output logic [31:0]      fetchAddr,
  output logic [31:0]      nextPtr,
  output logic [CNT_W-1:0] curCount,
  output logic             curChainEnd,
  output logic             curSel,
  output logic             bufChainEnd,
  output logic             bufSel
);

  localparam logic [31:0] SRC_STEP = 32'(1) << SRC_LOG2;
  localparam logic [31:0] DST_STEP = 32'(1) << DST_LOG2;
  localparam int          PAD_W    = 31 - CNT_W;

  logic [31:0] srcReg, dstReg, nextReg;
  logic [CNT_W-1:0] cntReg;
  logic [31:0] bufSrc, bufDst, bufNext;

  function automatic logic [31:0] maskNext(input logic [31:0] w);
    return {w[31:2], 1'b0, w[0]};
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcReg  <= '0;
      dstReg  <= '0;
      nextReg <= '0;
      cntReg  <= '0;
    end else if (strobe.swWrite) begin
      unique case (regAddr)
        SEL_SRC:  srcReg  <= regWdata;
        SEL_DST:  dstReg  <= regWdata;
        SEL_NEXT: nextReg <= maskNext(regWdata);
        SEL_CTRL: cntReg  <= regWdata[CNT_W-1:0];
        default:  ;
      endcase
    end else if (strobe.descLoad) begin
      srcReg  <= bufSrc;
      dstReg  <= bufDst;
      nextReg <= maskNext(bufNext);
      cntReg  <= fetchWord[CNT_W-1:0];
    end else if (strobe.beatStep) begin
      srcReg <= srcReg + SRC_STEP;
      dstReg <= dstReg + DST_STEP;
      cntReg <= cntReg - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufSrc  <= '0;
      bufDst  <= '0;
      bufNext <= '0;
    end else if (strobe.wordCapture) begin
      unique case (strobe.wordIdx)
        2'd0:    bufSrc  <= fetchWord;
        2'd1:    bufDst  <= fetchWord;
        2'd2:    bufNext <= fetchWord;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (regAddr)
      SEL_SRC:  regRdata = srcReg;
      SEL_DST:  regRdata = dstReg;
      SEL_NEXT: regRdata = nextReg;
      default:  regRdata = {chanEnabled, {PAD_W{1'b0}}, cntReg};
    endcase
  end

  assign srcAddr     = srcReg;
  assign dstAddr     = dstReg;
  assign nextPtr     = nextReg;
  assign curCount    = cntReg;
  assign fetchAddr   = {nextReg[31:2] + 30'(strobe.wordIdx), 2'b00};
  assign curChainEnd = (nextReg[31:2] == '0);
  assign curSel      = nextReg[0];
  assign bufChainEnd = (bufNext[31:2] == '0);
  assign bufSel      = bufNext[0];

endmodule

// File: rtl/lli_chain_seq.sv
module lli_chain_seq
  import lli_chain_pkg::*;
#(
  parameter int SRC_LOG2 = 2,
  parameter int DST_LOG2 = 2,
  parameter int CNT_W    = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        chanEnabled,
  output logic        chanActive,
  output logic        beatReq,
  input  logic        beatAck,
  output logic [31:0] beatSrcAddr,
  output logic [31:0] beatDstAddr,
  output logic        m1Req,
  output logic [31:0] m1Addr,
  input  logic        m1Ack,
  input  logic [31:0] m1Data,
  output logic        m2Req,
  output logic [31:0] m2Addr,
  input  logic        m2Ack,
  input  logic [31:0] m2Data
);

  seqStrobe_t       strobe;
  logic             fetchReq, fetchSel, fetchAck;
  logic [31:0]      fetchWord, fetchAddr, nextPtr;
  logic [CNT_W-1:0] curCount;
  logic             curChainEnd, curSel, bufChainEnd, bufSel;

  assign fetchAck  = fetchSel ? m2Ack : m1Ack;
  assign fetchWord = fetchSel ? m2Data : m1Data;
  assign m1Req     = fetchReq && !fetchSel;
  assign m2Req     = fetchReq && fetchSel;
  assign m1Addr    = fetchAddr;
  assign m2Addr    = fetchAddr;

  lli_chain_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .startCmd   ((regAddr == SEL_CTRL) && regWdata[31]),
    .startCount (regWdata[CNT_W-1:0]),
    .beatAck    (beatAck),
    .fetchAck   (fetchAck),
    .fetchCount (fetchWord[CNT_W-1:0]),
    .curCount   (curCount),
    .curChainEnd(curChainEnd),
    .curSel     (curSel),
    .bufChainEnd(bufChainEnd),
    .bufSel     (bufSel),
    .strobe     (strobe),
    .beatReq    (beatReq),
    .fetchReq   (fetchReq),
    .fetchSel   (fetchSel),
    .chanEnabled(chanEnabled),
    .chanActive (chanActive)
  );

  lli_chain_dp #(.SRC_LOG2(SRC_LOG2), .DST_LOG2(DST_LOG2), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .fetchWord  (fetchWord),
    .chanEnabled(chanEnabled),
    .regRdata   (regRdata),
    .srcAddr    (beatSrcAddr),
    .dstAddr    (beatDstAddr),
    .fetchAddr  (fetchAddr),
    .nextPtr    (nextPtr),
    .curCount   (curCount),
    .curChainEnd(curChainEnd),
    .curSel     (curSel),
    .bufChainEnd(bufChainEnd),
    .bufSel     (bufSel)
  );

endmodule

// File: rtl/lli_chain_chk.sv
module lli_chain_chk #(
  parameter int SRC_LOG2 = 2,
  parameter int DST_LOG2 = 2,
  parameter int CNT_W    = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWe,
  input logic [1:0]       regAddr,
  input logic             chanEnabled,
  input logic             chanActive,
  input logic             beatReq,
  input logic             beatAck,
  input logic [31:0]      beatSrcAddr,
  input logic [31:0]      beatDstAddr,
  input logic             m1Req,
  input logic             m2Req,
  input logic [31:0]      nextPtr,
  input logic [CNT_W-1:0] curCount
);

  localparam logic [31:0] SRC_STEP = 32'(1) << SRC_LOG2;
  localparam logic [31:0] DST_STEP = 32'(1) << DST_LOG2;

  a_r5_beat_needs_active: assert property (@(posedge clk) disable iff (!rstN)
    beatReq |-> chanActive);

  a_r6_single_port: assert property (@(posedge clk) disable iff (!rstN)
    !(m1Req && m2Req));

  a_r7_no_fetch_with_beat: assert property (@(posedge clk) disable iff (!rstN)
    !(beatReq && (m1Req || m2Req)));

  a_r4_src_step: assert property (@(posedge clk) disable iff (!rstN)
    (beatReq && beatAck && curCount > CNT_W'(1)) |=> beatSrcAddr == $past(beatSrcAddr) + SRC_STEP);

  a_r4_dst_step: assert property (@(posedge clk) disable iff (!rstN)
    (beatReq && beatAck && curCount > CNT_W'(1)) |=> beatDstAddr == $past(beatDstAddr) + DST_STEP);

  a_r9_fall_together: assert property (@(posedge clk) disable iff (!rstN)
    $fell(chanActive) |-> !chanEnabled);

  a_r3_next_held: assert property (@(posedge clk) disable iff (!rstN)
    (beatReq && regWe && regAddr == 2'd2) |=> nextPtr == $past(nextPtr));

endmodule

bind lli_chain_seq lli_chain_chk #(.SRC_LOG2(SRC_LOG2), .DST_LOG2(DST_LOG2), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWe      (regWe),
  .regAddr    (regAddr),
  .chanEnabled(chanEnabled),
  .chanActive (chanActive),
  .beatReq    (beatReq),
  .beatAck    (beatAck),
  .beatSrcAddr(beatSrcAddr),
  .beatDstAddr(beatDstAddr),
  .m1Req      (m1Req),
  .m2Req      (m2Req),
  .nextPtr    (nextPtr),
  .curCount   (curCount)
);

// File: tb/lli_chain_seq_tb.sv
`timescale 1ns/1ps
module lli_chain_seq_tb;

  localparam int SRC_LOG2 = 2;
  localparam int DST_LOG2 = 0;
  localparam int CNT_W    = 12;
  localparam logic [31:0] SSTEP = 32'(1) << SRC_LOG2;
  localparam logic [31:0] DSTEP = 32'(1) << DST_LOG2;

  // next-descriptor write value, expected read value (R2)
  localparam logic [63:0] NEXT_VEC [4] = '{
    {32'h0000_0106, 32'h0000_0104},
    {32'hFFFF_FFFF, 32'hFFFF_FFFD},
    {32'h1234_5671, 32'h1234_5671},
    {32'h0000_0002, 32'h0000_0000}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [31:0] regWdata = '0, regRdata;
  logic chanEnabled, chanActive, beatReq, beatAck = 1'b0;
  logic [31:0] beatSrcAddr, beatDstAddr;
  logic m1Req, m1Ack = 1'b0, m2Req, m2Ack = 1'b0;
  logic [31:0] m1Addr, m2Addr, m1Data = '0, m2Data = '0;

  int checks = 0, errors = 0;
  int beats = 0, fetchM1 = 0, fetchM2 = 0, fetchNo = 0;

  always #2 clk = ~clk;

  lli_chain_seq #(.SRC_LOG2(SRC_LOG2), .DST_LOG2(DST_LOG2), .CNT_W(CNT_W)) u_dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdata;
  endtask

  function automatic logic [31:0] memWord(input logic [31:0] a);
    case (a)
      32'h100: return 32'h0000_3000;
      32'h104: return 32'h0000_4000;
      32'h108: return 32'h0000_0201;
      32'h10C: return 32'h0000_0002;
      32'h200: return 32'h0000_5000;
      32'h204: return 32'h0000_6000;
      32'h208: return 32'h0000_0000;
      32'h20C: return 32'hABC0_0000;
      default: return 32'hDEAD_BEEF;
    endcase
  endfunction

  // Serve beats and fetches until the channel goes idle
  task automatic runChain(input logic [31:0] src0, input logic [31:0] dst0,
                          input logic [31:0] base0, input logic sel0,
                          input int maxCyc);
    logic [31:0] expSrc = src0, expDst = dst0, fBase = base0;
    logic fSel = sel0;
    int fIdx = 0;
    logic toggle = 1'b1;
    logic [31:0] w0 = '0, w1 = '0, w2 = '0, fAddr;
    int enMismatch = 0, overlap = 0;
    for (int c = 0; c < maxCyc; c++) begin
      @(negedge clk);
      beatAck = 1'b0; m1Ack = 1'b0; m2Ack = 1'b0;
      regAddr = 2'd3;
      #0.5;
      if (regRdata[31] !== chanActive) enMismatch++;
      if (!chanActive) break;
      if (beatReq) begin
        check("R4 beat source address", beatSrcAddr, expSrc);
        check("R4 beat destination address", beatDstAddr, expDst);
        if (toggle) begin
          beatAck = 1'b1;
          expSrc += SSTEP; expDst += DSTEP; beats++;
        end
        toggle = !toggle;
      end
      if (m1Req || m2Req) begin
        if (beatReq) overlap++;
        check("R6 port choice", 32'(m2Req), 32'(fSel));
        fAddr = m2Req ? m2Addr : m1Addr;
        check("R6 fetch word address", fAddr, fBase + 32'(4 * fIdx));
        if (fIdx == 0) begin
          fetchNo++;
          check("R7 beats done before fetch", 32'(beats), fetchNo == 1 ? 32'd3 : 32'd5);
        end
        if (m2Req) begin m2Data = memWord(fAddr); m2Ack = 1'b1; fetchM2++; end
        else begin m1Data = memWord(fAddr); m1Ack = 1'b1; fetchM1++; end
        case (fIdx)
          0: w0 = memWord(fAddr);
          1: w1 = memWord(fAddr);
          2: w2 = memWord(fAddr);
          default: ;
        endcase
        fIdx++;
        if (fIdx == 4) begin
          expSrc = w0; expDst = w1;
          fBase = {w2[31:2], 2'b00}; fSel = w2[0]; fIdx = 0;
        end
      end
    end
    beatAck = 1'b0; m1Ack = 1'b0; m2Ack = 1'b0;
    check("R9 enable and active fall together", 32'(enMismatch), 32'd0);
    check("R7 no fetch during beat", 32'(overlap), 32'd0);
    check("R9 channel stopped", 32'(chanActive), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(2'd0, rd); check("R1 source reset", rd, 32'h0);
    regRead(2'd1, rd); check("R1 destination reset", rd, 32'h0);
    regRead(2'd2, rd); check("R1 next reset", rd, 32'h0);
    regRead(2'd3, rd); check("R1 enable reset", 32'(rd[31]), 32'h0);
    check("R1 outputs idle", {28'h0, chanActive, beatReq, m1Req, m2Req}, 32'h0);

    // R2 table of next-descriptor writes
    for (int i = 0; i < 4; i++) begin
      regWrite(2'd2, NEXT_VEC[i][63:32]);
      regRead(2'd2, rd);
      check("R2 next-descriptor readback", rd, NEXT_VEC[i][31:0]);
    end

    // R10 zero count with zero pointer: one active cycle, no beats
    regWrite(2'd2, 32'h0);
    regWrite(2'd3, 32'h8000_0000);
    check("R10 active during stop cycle", 32'(chanActive), 32'd1);
    check("R10 no beat on zero count", 32'(beatReq), 32'd0);
    @(negedge clk);
    check("R10 stopped after zero count", 32'(chanActive), 32'd0);

    // R3 writes ignored while enabled
    regWrite(2'd0, 32'h7000);
    regWrite(2'd1, 32'h7100);
    regWrite(2'd2, 32'h0);
    regWrite(2'd3, 32'h8000_0001);
    check("R11 active after start", 32'(chanActive), 32'd1);
    regWrite(2'd2, 32'h0000_0400);
    regWrite(2'd0, 32'h0000_9999);
    regRead(2'd2, rd); check("R3 next write ignored", rd, 32'h0);
    regRead(2'd0, rd); check("R3 source write ignored", rd, 32'h7000);
    beats = 0; fetchNo = 0;
    runChain(32'h7000, 32'h7100, 32'h0, 1'b0, 50);
    check("R5 single beat", 32'(beats), 32'd1);
    regRead(2'd0, rd); check("R4 source after beat", rd, 32'h7004);
    regRead(2'd1, rd); check("R4 destination after beat", rd, 32'h7101);

    // R6 R8 chain through both ports
    regWrite(2'd0, 32'h1000);
    regWrite(2'd1, 32'h2000);
    regWrite(2'd2, 32'h0000_0100);
    beats = 0; fetchM1 = 0; fetchM2 = 0; fetchNo = 0;
    regWrite(2'd3, 32'h8000_0003);
    runChain(32'h1000, 32'h2000, 32'h100, 1'b0, 200);
    check("R5 total beats", 32'(beats), 32'd5);
    check("R6 port 1 words", 32'(fetchM1), 32'd4);
    check("R6 port 2 words", 32'(fetchM2), 32'd4);
    regRead(2'd0, rd); check("R8 source reloaded", rd, 32'h5000);
    regRead(2'd1, rd); check("R8 destination reloaded", rd, 32'h6000);
    regRead(2'd2, rd); check("R8 next reloaded", rd, 32'h0);
    regRead(2'd3, rd); check("R10 loaded count zero", rd, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule